// File: doc/BRIEF.md
# Complementary PWM Dead-Band Generator

This block turns one or two raw PWM waveforms into a pair of outputs whose edges are held apart by programmable guard intervals. Two delay paths run side by side. The rising-edge path holds back each low-to-high transition of its source by a configured number of clocks. The falling-edge path holds back each high-to-low transition of its source in the same way. Each path lets the opposite transition through after the one-clock register stage that all paths share.

Three two-bit configuration fields control the block. The source field picks the raw input that feeds each path. The inversion field picks which path results are inverted. The routing field picks, for each output, either the delayed path or a registered copy of the matching raw input. The usual setting drives both paths from raw A, inverts the falling-edge path and routes both delayed paths to the outputs. With that setting, output B is the complement of output A and the two outputs are never high together. Configuration is expected to stay stable while the block runs.

Top module: `pwm_deadband`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both delay paths read 0, so each routed output equals its inversion bit, and each bypassed output reads 0.
- R2: The rising-edge path goes to 1 after its source has been sampled high on rise_dly+1 consecutive clock edges. It returns to 0 one clock after its source is sampled low.
- R3: The falling-edge path goes to 1 one clock after its source is sampled high. It returns to 0 only after its source has been sampled low on fall_dly+1 consecutive clock edges.
- R4: A source pulse that is high for rise_dly sampled edges or fewer gives no pulse at all on the rising-edge path. A low gap of fall_dly sampled edges or fewer leaves the falling-edge path high throughout.
- R5: pol_sel[0]=1 inverts the rising-edge path result and pol_sel[1]=1 inverts the falling-edge path result. The codes are 00 active high, 01 active low complementary, 10 active high complementary and 11 active low.
- R6: out_mode[1]=1 routes the rising-edge path to out_a and out_mode[0]=1 routes the falling-edge path to out_b. A 0 in either bit routes the registered raw input instead, and inversion is not applied to it. Code 00 is full bypass and 11 is full enable.
- R7: in_sel[0] picks the rising-edge path source and in_sel[1] picks the falling-edge path source, with 0 for raw_a and 1 for raw_b. Code 00 feeds raw_a to both paths.
- R8: With in_sel=00, pol_sel=10 and out_mode=11, out_a and out_b are never high in the same cycle.
- R9: A bypassed output equals its raw input as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_a | input | 1 | Raw PWM input A |
| raw_b | input | 1 | Raw PWM input B |
| in_sel | input | 2 | Source select for the rising-edge path (bit 0) and the falling-edge path (bit 1) |
| pol_sel | input | 2 | Inversion select for the rising-edge path (bit 0) and the falling-edge path (bit 1) |
| out_mode | input | 2 | Routing select for out_b (bit 0) and out_a (bit 1) |
| rise_dly | input | DLY_W | Rising-edge delay in clocks |
| fall_dly | input | DLY_W | Falling-edge delay in clocks |
| out_a | output | 1 | Output A |
| out_b | output | 1 | Output B |

## Verification
The properties assume that the configuration fields stay constant while reset is deasserted. They also assume that raw inputs change only between clock edges, so that each edge samples a settled source value.

The stimulus follows these assumptions. For each combination of source, inversion, routing and delays from 0 to 3, the bench applies the configuration and then resets the block. It changes the raw inputs only on falling clock edges. The raw pulse widths cycle from 1 to 5 clocks, so they fall below, on and above every delay under test. Expected outputs come from windows over the recorded input history.

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_a,
  input  logic             raw_b,
  input  logic [1:0]       in_sel,
  input  logic [1:0]       pol_sel,
  input  logic [1:0]       out_mode,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  output logic             out_a,
  output logic             out_b
);

  logic             red_src, fed_src;
  logic             red_q, fed_q;
  logic             byp_a_q, byp_b_q;
  logic [DLY_W-1:0] red_cnt, fed_cnt;

  assign red_src = in_sel[0] ? raw_b : raw_a;
  assign fed_src = in_sel[1] ? raw_b : raw_a;

  // Rising-edge path: counts sampled-high edges, releases once the count reaches rise_dly.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_cnt <= '0;
      red_q   <= 1'b0;
    end else if (!red_src) begin
      red_cnt <= '0;
      red_q   <= 1'b0;
    end else if (red_cnt >= rise_dly) begin
      red_q   <= 1'b1;
    end else begin
      red_cnt <= red_cnt + 1'b1;
    end
  end

  // Falling-edge path: mirror image, counting sampled-low edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fed_cnt <= '0;
      fed_q   <= 1'b0;
    end else if (fed_src) begin
      fed_cnt <= '0;
      fed_q   <= 1'b1;
    end else if (fed_cnt >= fall_dly) begin
      fed_q   <= 1'b0;
    end else begin
      fed_cnt <= fed_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_a_q <= 1'b0;
      byp_b_q <= 1'b0;
    end else begin
      byp_a_q <= raw_a;
      byp_b_q <= raw_b;
    end
  end

  assign out_a = out_mode[1] ? (red_q ^ pol_sel[0]) : byp_a_q;
  assign out_b = out_mode[0] ? (fed_q ^ pol_sel[1]) : byp_b_q;

endmodule

module pwm_deadband_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       raw_a,
  input logic       raw_b,
  input logic [1:0] in_sel,
  input logic [1:0] pol_sel,
  input logic [1:0] out_mode,
  input logic       red_src,
  input logic       fed_src,
  input logic       red_q,
  input logic       fed_q,
  input logic       out_a,
  input logic       out_b
);

  assert_rise_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !red_src |=> !red_q);

  assert_rise_needs_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(red_q)) |-> $past(red_src));

  assert_fall_path_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fed_src |=> fed_q);

  assert_fall_needs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(fed_q)) |-> !$past(fed_src));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sel == 2'b00 && pol_sel == 2'b10 && out_mode == 2'b11) |-> !(out_a && out_b));

  assert_bypass_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !out_mode[1]) |-> (out_a == $past(raw_a)));

  assert_bypass_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !out_mode[0]) |-> (out_b == $past(raw_b)));

endmodule

bind pwm_deadband pwm_deadband_chk u_chk (.*);

// File: tb/pwm_deadband_bench.sv
module pwm_deadband_bench;
  localparam int W = 8;
  localparam int N = 40;

  logic clk = 1'b0, rst_n = 1'b0, raw_a = 1'b0, raw_b = 1'b0;
  logic [1:0] in_sel = '0, pol_sel = '0, out_mode = '0;
  logic [W-1:0] rise_dly = '0, fall_dly = '0;
  logic out_a, out_b;
  int checks = 0, fails = 0;
  logic [N-1:0] ha, hb;

  always #2 clk = ~clk;

  pwm_deadband #(.DLY_W(W)) u_pwm_deadband (
    .clk(clk), .rst_n(rst_n), .raw_a(raw_a), .raw_b(raw_b),
    .in_sel(in_sel), .pol_sel(pol_sel), .out_mode(out_mode),
    .rise_dly(rise_dly), .fall_dly(fall_dly), .out_a(out_a), .out_b(out_b));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b (sel=%b pol=%b mode=%b rd=%0d fd=%0d)",
               tag, act, exp, in_sel, pol_sel, out_mode, rise_dly, fall_dly);
    end
  endtask

  function automatic logic win_all(input logic [N-1:0] h, input int t, input int d);
    for (int j = 0; j <= d; j++) begin
      if (t - 1 - j < 0) return 1'b0;
      if (!h[t-1-j]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic win_any(input logic [N-1:0] h, input int t, input int d);
    for (int j = 0; j <= d; j++) begin
      if (t - 1 - j >= 0 && h[t-1-j]) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; raw_a = 1'b0; raw_b = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_cfg();
    int ca = 1, cb = 2, ka = 0, kb = 1;
    logic [N-1:0] sr, sf;
    logic ea, eb, pa, pb;
    string ta, tb;
    ha = '0; hb = '0;
    for (int t = 0; t < N; t++) begin
      sr = in_sel[0] ? hb : ha;
      sf = in_sel[1] ? hb : ha;
      pa = (t > 0) ? ha[t-1] : 1'b0;
      pb = (t > 0) ? hb[t-1] : 1'b0;
      ea = out_mode[1] ? (win_all(sr, t, int'(rise_dly)) ^ pol_sel[0]) : pa;
      eb = out_mode[0] ? (win_any(sf, t, int'(fall_dly)) ^ pol_sel[1]) : pb;
      if (t == 0) begin
        ta = "R1 out_a"; tb = "R1 out_b";
      end else begin
        ta = out_mode[1] ? (pol_sel[0] ? "R5 R6 R7 out_a" : "R2 R6 R7 out_a") : "R9 R6 out_a";
        tb = out_mode[0] ? (pol_sel[1] ? "R5 R6 R7 out_b" : "R3 R6 R7 out_b") : "R9 R6 out_b";
      end
      chk(ta, out_a, ea);
      chk(tb, out_b, eb);
      if (in_sel == 2'b00 && pol_sel == 2'b10 && out_mode == 2'b11)
        chk("R8 overlap", out_a & out_b, 1'b0);
      ca--; cb--;
      if (ca == 0) begin raw_a = ~raw_a; ka++; ca = (ka * 3) % 5 + 1; end
      if (cb == 0) begin raw_b = ~raw_b; kb++; cb = (kb * 2) % 5 + 1; end
      ha[t] = raw_a; hb[t] = raw_b;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic seen_a, lost_b, b_up;
    @(negedge clk);
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 4; s++)
          for (int rd = 0; rd < 4; rd++)
            for (int fd = 0; fd < 4; fd++) begin
              out_mode = 2'(m); pol_sel = 2'(p); in_sel = 2'(s);
              rise_dly = W'(rd); fall_dly = W'(fd);
              do_reset();
              run_cfg();
            end

    // R4: pulse as long as the rising delay is swallowed; short low gap is bridged
    in_sel = 2'b00; pol_sel = 2'b00; out_mode = 2'b11;
    rise_dly = W'(3); fall_dly = W'(3);
    do_reset();
    seen_a = 1'b0;
    raw_a = 1'b1;
    repeat (3) @(negedge clk);
    raw_a = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (out_a) seen_a = 1'b1;
      @(negedge clk);
    end
    chk("R4 short pulse on rising path", seen_a, 1'b0);

    lost_b = 1'b0; b_up = 1'b0;
    raw_a = 1'b1;
    repeat (6) @(negedge clk);
    raw_a = 1'b0;
    repeat (3) @(negedge clk);
    raw_a = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (out_b) b_up = 1'b1;
      else if (b_up) lost_b = 1'b1;
      @(negedge clk);
    end
    chk("R4 short gap on falling path", lost_b, 1'b0);
    chk("R4 falling path high", out_b, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule